// File: doc/BRIEF.md
# Proximity FSK Waveform Generator

This block produces the serial sample stream of a 125 kHz proximity tag that repeatedly transmits a 44-bit identifier using frequency-shift keying. Every sample is one bit, emitted on a carrier-clock enable. The stream is built from two fixed groups of samples. The fast group has a period of 8 samples and spans 48 samples. The slow group has a period of 10 samples and spans 50 samples. Each identifier bit is Manchester-coded as a pair of groups. An extra fast group separates every nibble. Each frame opens with a start marker made of group pairs that are deliberately not valid Manchester symbols.

The surrounding logic supplies the identifier and a run level, and it pulses the enable once per carrier sample. The block's output feeds the modulation path. Frames follow each other with no gap for as long as run stays high. Dropping run stops the stream and pulls the output low. Raising run again starts a fresh frame from its first sample.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: A fast group is 48 samples made of the 8-sample pattern 1,1,0,0,0,0,0,0 repeated 6 times, emitted left to right, so each group starts with a 1.
- R2: A slow group is 50 samples made of the 10-sample pattern 1,1,1,0,0,0,0,0,0,0 repeated 5 times, emitted left to right.
- R3: Every frame opens with the start marker fast, fast, fast, slow, slow, slow, fast, slow.
- R4: Identifier bits follow the marker from bit 43 down to bit 0. A 1 is sent as fast then slow, and a 0 as slow then fast.
- R5: One extra fast group comes directly before bits 43, 39, 35, …, 7 and 3, that is, before every bit whose index modulo 4 is 3.
- R6: A frame is 5232 samples long. The next frame's first sample follows the previous frame's last sample on the very next enable.
- R7: One sample is produced per enable while running. The output holds its value in cycles without an enable.
- R8: The identifier is captured while stopped and again on the last sample of each frame. A change in the middle of a frame first shows up in the following frame.
- R9: When run is low, the output is 0 after the next clock edge and stays 0. When run rises, the next enable produces sample 0 of a new frame.
- R10: During and after reset, and before run is raised, the output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_i | input | 1 | High to transmit frames; low to stop and hold the frame start |
| ce_i | input | 1 | Carrier-clock enable, one pulse per output sample |
| id_i | input | 44 | Identifier to transmit, bit 43 sent first |
| sample_o | output | 1 | Registered sample stream |

## Verification
The bench builds the expected sample sequence of a whole frame arithmetically from the identifier. It compares every sample across several identifiers: a mixed pattern, all zeros, all ones and a second irregular word. All zeros and all ones show that the Manchester order of the two groups is right for each bit value. The irregular words expose any wrong bit order or misplaced nibble spacer. Back-to-back frames with an identifier change halfway separate seamless restart from capture at the frame boundary. A run with sparse enables and a stop in mid-frame show that the output holds between enables and is forced low by stop.

// File: rtl/fsk_wave_pkg.sv
package fsk_wave_pkg;
  // Sub-pattern selector: fast = period 8, slow = period 10
  typedef enum logic {
    GRP_FAST = 1'b0,
    GRP_SLOW = 1'b1
  } grp_kind_e;

  typedef enum logic [1:0] {
    PH_MARK   = 2'd0,
    PH_SPACER = 2'd1,
    PH_HALF_A = 2'd2,
    PH_HALF_B = 2'd3
  } frame_phase_e;
endpackage

// File: rtl/fsk_group_gen.sv
module fsk_group_gen
  import fsk_wave_pkg::*;
#(
  parameter int FAST_DIV  = 8,
  parameter int FAST_HIGH = 2,
  parameter int FAST_REPS = 6,
  parameter int SLOW_DIV  = 10,
  parameter int SLOW_HIGH = 3,
  parameter int SLOW_REPS = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_i,
  input  logic      step_i,
  input  grp_kind_e kind_i,
  output logic      bit_o,
  output logic      last_o
);
  localparam int MAX_DIV  = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int MAX_REPS = (SLOW_REPS > FAST_REPS) ? SLOW_REPS : FAST_REPS;
  localparam int POS_W    = $clog2(MAX_DIV);
  localparam int REP_W    = (MAX_REPS > 1) ? $clog2(MAX_REPS) : 1;

  logic [POS_W-1:0] pos_q, pos_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic [POS_W-1:0] pos_end, pos_high;
  logic [REP_W-1:0] rep_end;
  logic             wrap_pos;

  always_comb begin
    if (kind_i == GRP_SLOW) begin
      pos_end  = POS_W'(SLOW_DIV - 1);
      pos_high = POS_W'(SLOW_HIGH);
      rep_end  = REP_W'(SLOW_REPS - 1);
    end else begin
      pos_end  = POS_W'(FAST_DIV - 1);
      pos_high = POS_W'(FAST_HIGH);
      rep_end  = REP_W'(FAST_REPS - 1);
    end
  end

  assign wrap_pos = (pos_q == pos_end);
  assign bit_o    = (pos_q < pos_high);
  assign last_o   = wrap_pos && (rep_q == rep_end);

  always_comb begin
    pos_d = pos_q;
    rep_d = rep_q;
    if (!run_i) begin
      pos_d = '0;
      rep_d = '0;
    end else if (step_i) begin
      if (wrap_pos) begin
        pos_d = '0;
        rep_d = last_o ? '0 : rep_q + 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      rep_q <= '0;
    end else begin
      pos_q <= pos_d;
      rep_q <= rep_d;
    end
  end

  // R1 R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q <= pos_end) && (rep_q <= rep_end));

  // R1 R2
  kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !(step_i && last_o)) |=> $stable(kind_i));
endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
  import fsk_wave_pkg::*;
#(
  parameter int              ID_W     = 44,
  parameter int              NIB      = 4,
  parameter int              MARK_LEN = 8,
  parameter logic [MARK_LEN-1:0] MARK_SLOW = 8'hB8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            adv_i,
  input  logic [ID_W-1:0] id_i,
  output grp_kind_e       kind_o
);
  localparam int   BIT_W     = $clog2(ID_W);
  localparam int   MARK_W    = (MARK_LEN > 1) ? $clog2(MARK_LEN) : 1;
  localparam int   NIB_TOP   = NIB - 1;
  localparam logic TOP_SPACE = (((ID_W - 1) % NIB) == NIB_TOP);

  frame_phase_e      phase_q, phase_d;
  logic [MARK_W-1:0] mark_q, mark_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic              cur_bit, frame_end;
  logic [BIT_W-1:0]  bit_dec;

  assign cur_bit   = id_q[bit_q];
  assign frame_end = (phase_q == PH_HALF_B) && (bit_q == '0);
  assign bit_dec   = bit_q - 1'b1;

  always_comb begin
    unique case (phase_q)
      PH_MARK:   kind_o = MARK_SLOW[mark_q] ? GRP_SLOW : GRP_FAST;
      PH_SPACER: kind_o = GRP_FAST;
      PH_HALF_A: kind_o = cur_bit ? GRP_FAST : GRP_SLOW;
      default:   kind_o = cur_bit ? GRP_SLOW : GRP_FAST;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    mark_d  = mark_q;
    bit_d   = bit_q;
    id_d    = id_q;
    if (!run_i) begin
      phase_d = PH_MARK;
      mark_d  = '0;
      bit_d   = BIT_W'(ID_W - 1);
      id_d    = id_i;
    end else if (adv_i) begin
      unique case (phase_q)
        PH_MARK: begin
          if (mark_q == MARK_W'(MARK_LEN - 1)) begin
            phase_d = TOP_SPACE ? PH_SPACER : PH_HALF_A;
            bit_d   = BIT_W'(ID_W - 1);
          end else begin
            mark_d = mark_q + 1'b1;
          end
        end
        PH_SPACER: phase_d = PH_HALF_A;
        PH_HALF_A: phase_d = PH_HALF_B;
        default: begin
          if (frame_end) begin
            phase_d = PH_MARK;
            mark_d  = '0;
            bit_d   = BIT_W'(ID_W - 1);
            id_d    = id_i;
          end else begin
            bit_d   = bit_dec;
            phase_d = ((int'(bit_dec) % NIB) == NIB_TOP) ? PH_SPACER : PH_HALF_A;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_MARK;
      mark_q  <= '0;
      bit_q   <= BIT_W'(ID_W - 1);
      id_q    <= '0;
    end else begin
      phase_q <= phase_d;
      mark_q  <= mark_d;
      bit_q   <= bit_d;
      id_q    <= id_d;
    end
  end

  // R8
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !(adv_i && frame_end)) |=> $stable(id_q));

  // R5
  mark_to_spacer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && adv_i && phase_q == PH_MARK && mark_q == MARK_W'(MARK_LEN - 1))
      |=> (phase_q == PH_SPACER && bit_q == BIT_W'(ID_W - 1)));

  // R4
  half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && adv_i && phase_q == PH_HALF_A) |=> (phase_q == PH_HALF_B && $stable(bit_q)));
endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen
  import fsk_wave_pkg::*;
#(
  parameter int ID_W      = 44,
  parameter int NIB       = 4,
  parameter int FAST_DIV  = 8,
  parameter int FAST_HIGH = 2,
  parameter int FAST_REPS = 6,
  parameter int SLOW_DIV  = 10,
  parameter int SLOW_HIGH = 3,
  parameter int SLOW_REPS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            ce_i,
  input  logic [ID_W-1:0] id_i,
  output logic            sample_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       step, adv, grp_bit, grp_last, sample_d, sample_q;
  grp_kind_e  kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign step = run_i && ce_i;
  assign adv  = step && grp_last;

  fsk_frame_seq #(
    .ID_W(ID_W), .NIB(NIB)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .run_i(run_i), .adv_i(adv),
    .id_i(id_i), .kind_o(kind)
  );

  fsk_group_gen #(
    .FAST_DIV(FAST_DIV), .FAST_HIGH(FAST_HIGH), .FAST_REPS(FAST_REPS),
    .SLOW_DIV(SLOW_DIV), .SLOW_HIGH(SLOW_HIGH), .SLOW_REPS(SLOW_REPS)
  ) u_grp (
    .clk(clk), .rst_n(rst_int_n), .run_i(run_i), .step_i(step),
    .kind_i(kind), .bit_o(grp_bit), .last_o(grp_last)
  );

  always_comb begin
    sample_d = sample_q;
    if (!run_i)    sample_d = 1'b0;
    else if (step) sample_d = grp_bit;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sample_q <= 1'b0;
    else            sample_q <= sample_d;
  end
  assign sample_o = sample_q;

  // R9
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !run_i |=> !sample_o);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run_i && !ce_i) |=> $stable(sample_o));
endmodule

// File: tb/tb_fsk_tag_wavegen.sv
module tb_fsk_tag_wavegen;
  localparam int FRAME = 5232;

  logic        clk, rst_n, run_i, ce_i, sample_o;
  logic [43:0] id_i;
  int          n_chk, n_fail;
  bit          done;
  bit          ex [0:FRAME-1];
  string       tg [0:FRAME-1];
  int          wr;

  fsk_tag_wavegen dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .ce_i(ce_i),
    .id_i(id_i), .sample_o(sample_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string rq, logic act, logic exp, int idx);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s sample %0d: actual=%0b expected=%0b", rq, idx, act, exp);
    end
  endtask

  task automatic put_grp(int div, string t);
    int hi, reps;
    hi   = (div == 8) ? 2 : 3;
    reps = (div == 8) ? 6 : 5;
    for (int r = 0; r < reps; r++)
      for (int p = 0; p < div; p++) begin
        ex[wr] = (p < hi);
        tg[wr] = t;
        wr++;
      end
  endtask

  task automatic build(logic [43:0] id);
    int mk [8] = '{8, 8, 8, 10, 10, 10, 8, 10};
    wr = 0;
    for (int g = 0; g < 8; g++) put_grp(mk[g], "R3");
    for (int i = 43; i >= 0; i--) begin
      if (i % 4 == 3) put_grp(8, "R5");
      if (id[i]) begin put_grp(8, "R4"); put_grp(10, "R4"); end
      else       begin put_grp(10, "R4"); put_grp(8, "R4"); end
    end
    n_chk++;
    if (wr != FRAME) begin
      n_fail++;
      $display("FAIL R6 frame length: actual=%0d expected=%0d", wr, FRAME);
    end
  endtask

  // Stream one frame; gap = idle cycles between enables; chg_at >= 0 changes id there
  task automatic stream(int gap, bit cont, int chg_at, logic [43:0] nid);
    for (int k = 0; k < FRAME; k++) begin
      string t;
      ce_i = 1'b1;
      if (k == chg_at) id_i = nid;
      @(negedge clk);
      t = tg[k];
      if (cont && k == 0) t = "R6";
      if (chg_at >= 0 && k >= chg_at) t = "R8";
      check(t, sample_o, ex[k], k);
      if (k < 48) check("R1", sample_o, ((k % 8) < 2), k);
      if (k >= 144 && k < 194) check("R2", sample_o, (((k - 144) % 10) < 3), k);
      ce_i = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        check("R7", sample_o, ex[k], k);
      end
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [43:0] id_a, id_b;
    n_chk = 0; n_fail = 0; done = 0;
    id_a = 44'h5A3_C96E_1F0B;
    id_b = 44'hB1E_0F4D_27C6;
    rst_n = 1'b0; run_i = 1'b0; ce_i = 1'b0; id_i = id_a;
    repeat (3) @(negedge clk);
    check("R10", sample_o, 1'b0, 0);
    rst_n = 1'b1;
    ce_i = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R10", sample_o, 1'b0, 0);
    end
    ce_i = 1'b0;

    // Mixed id, two frames back to back, id change in the middle of the second
    build(id_a);
    run_i = 1'b1;
    stream(0, 1'b0, -1, id_a);
    stream(0, 1'b1, 2000, id_b);
    build(id_b);
    stream(0, 1'b1, -1, id_b);

    // Stop in the middle of a frame
    stream_part_stop();

    // All zeros captured while stopped, sparse enables
    build(44'h0);
    run_i = 1'b1;
    stream(2, 1'b0, -1, 44'h0);

    // All ones
    run_i = 1'b0;
    id_i  = {44{1'b1}};
    @(negedge clk);
    build({44{1'b1}});
    run_i = 1'b1;
    stream(0, 1'b0, -1, {44{1'b1}});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic stream_part_stop();
    for (int k = 0; k < 700; k++) begin
      ce_i = 1'b1;
      @(negedge clk);
      check("R9", sample_o, ex[k], k);
    end
    run_i = 1'b0;
    id_i  = 44'h0;
    @(negedge clk);
    check("R9", sample_o, 1'b0, 700);
    for (int k = 0; k < 20; k++) begin
      ce_i = k[0];
      @(negedge clk);
      check("R9", sample_o, 1'b0, 700 + k);
    end
    ce_i = 1'b0;
  endtask
endmodule